// File: doc/BRIEF.md
# Hybrid Integrator Accumulation Register

This block is the digital half of a hybrid integrator. Its input is the coarse binary part of an integrand. Once per integration interval, marked by a one-cycle `tick` strobe, that value is added into the low end of an n-bit accumulator. The top bits of the accumulator are the coarse binary part of the integral. The remaining low bits go out as a code for an external D/A converter, whose voltage is summed with the analog terms of the integral.

An external dual-threshold comparator watches that analog sum and raises one of two request lines. The up request means the sum crossed the upper threshold, so one unit must move into the register. The down request means the sum fell below the lower threshold, so a unit previously moved must be taken back. Both lines may change at any time relative to the clock. Each line passes through a two-stage synchroniser and a small request state machine. That machine fires exactly one update per assertion. The interval addition and any request pulses due in the same cycle are merged into one update. The register wraps modulo 2^n, and a sticky flag records that a wrap occurred.

Each request line has its own state machine with three states. `REQ_IDLE` waits for the synchronised line to be high and then moves to `REQ_FIRE`. `REQ_FIRE` lasts one cycle and drives the update pulse. From there it moves to `REQ_HOLD` if the line is still high, or back to `REQ_IDLE` if it is not. `REQ_HOLD` stays put while the line is high and returns to `REQ_IDLE` once the line is low.

Top module: `hyb_integ_acc`

## Requirements
- R1: During and right after reset, `dig_out`, `dac_code` and `ovf` are all zero.
- R2: At a clock edge where `tick` is high, `din` is added to the accumulator. While `tick` is low, `din` has no effect on the accumulator.
- R3: `dig_out` is bits [10:8] of the 11-bit accumulator and `dac_code` is bits [7:0]. The visible value is therefore `{dig_out, dac_code}`.
- R4: When `carry_up` rises, the accumulator goes up by exactly 1. The new value is visible after the fourth rising clock edge that follows the change: two synchroniser stages, one state-machine edge and one register edge.
- R5: When `carry_dn` rises, the accumulator goes down by exactly 1, with the same four-edge latency as R4.
- R6: When a tick and a request pulse fall on the same edge, the accumulator takes `din` plus or minus 1 in one update.
- R7: The accumulator wraps modulo 2^11, both upward past 2047 and downward below 0. Any wrap sets `ovf`, and `ovf` stays high until reset.
- R8: An up pulse and a down pulse on the same edge cancel, and the accumulator is unchanged.
- R9: A request line held high for many cycles changes the accumulator only once. It must return low before it can fire again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Interval strobe, one cycle wide |
| din | input | 3 | Coarse binary part of the integrand |
| carry_up | input | 1 | Upper-threshold request, not synchronous to `clk` |
| carry_dn | input | 1 | Lower-threshold request, not synchronous to `clk` |
| dig_out | output | 3 | Coarse binary part of the integral |
| dac_code | output | 8 | Low accumulator bits, sent to the D/A converter |
| ovf | output | 1 | Sticky wrap flag |

## Verification
The interval addition is exercised with several `din` values, including 0 and the maximum of 7. This separates a correct add from a missed tick or a constant offset. Values of `din` changed while `tick` is low show whether the tick gate is working. Requests are exercised in four ways: a lone rising edge, a line held high, an up and a down arriving together, and a request landing on the same edge as a tick. These separate wrong latency, repeated firing, lost cancellation and a merged update that drops one of its terms. A long run of ticks past 2047, and a borrow taken from zero, check the wrap in both directions and the stickiness of `ovf`.

// File: rtl/hia_pkg.sv
package hia_pkg;
    typedef enum logic [1:0] {
        REQ_IDLE = 2'd0,
        REQ_FIRE = 2'd1,
        REQ_HOLD = 2'd2
    } req_state_t;

    localparam int REQ_UP = 0;
    localparam int REQ_DN = 1;
    localparam int REQ_N  = 2;
endpackage

// File: rtl/hia_req_sync.sv
module hia_req_sync
    import hia_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_async,
    output logic pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   req_s;
    req_state_t             state_q;
    req_state_t             state_d;

    // synchroniser chain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], req_async};
        end
    end

    assign req_s = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: state_d = req_s ? REQ_FIRE : REQ_IDLE;
            REQ_FIRE: state_d = req_s ? REQ_HOLD : REQ_IDLE;
            REQ_HOLD: state_d = req_s ? REQ_HOLD : REQ_IDLE;
            default:  state_d = REQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pulse = 1'b0;
        unique case (state_q)
            REQ_FIRE: pulse = 1'b1;
            default:  pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/hia_step_calc.sv
module hia_step_calc #(
    parameter int ACC_W = 11,
    parameter int IN_W  = 3
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             tick,
    input  logic [IN_W-1:0]  din,
    input  logic             inc,
    input  logic             dec,
    output logic [ACC_W-1:0] acc_nxt,
    output logic             wrap
);
    localparam int HI_W  = ACC_W - IN_W;
    localparam int EXT_W = ACC_W + 2;

    logic [IN_W-1:0]  din_g;
    logic [IN_W:0]    lo_sum;
    logic [HI_W+1:0]  hi_sum;
    logic [EXT_W-1:0] staged;
    logic [EXT_W-1:0] incdec;
    logic [EXT_W-1:0] total;

    // input bits gated by the interval strobe
    assign din_g  = tick ? din : '0;
    // small adder on the low stages
    assign lo_sum = {1'b0, acc[IN_W-1:0]} + {1'b0, din_g};
    // ripple the low carry into the upper counter stages
    assign hi_sum = {2'b00, acc[ACC_W-1:IN_W]} + {{(HI_W+1){1'b0}}, lo_sum[IN_W]};
    assign staged = {hi_sum, lo_sum[IN_W-1:0]};

    // comparator carry (+1) or borrow (-1)
    always_comb begin
        incdec = '0;
        if (inc && !dec) begin
            incdec = {{(EXT_W-1){1'b0}}, 1'b1};
        end else if (dec && !inc) begin
            incdec = '1;
        end
    end

    assign total   = staged + incdec;
    assign acc_nxt = total[ACC_W-1:0];
    assign wrap    = |total[EXT_W-1:ACC_W];
endmodule

// File: rtl/hia_acc_reg.sv
module hia_acc_reg #(
    parameter int ACC_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_nxt,
    input  logic             wrap,
    output logic [ACC_W-1:0] acc_q,
    output logic             ovf_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            acc_q <= acc_nxt;
            ovf_q <= ovf_q | wrap;
        end
    end
endmodule

// File: rtl/hyb_integ_acc.sv
module hyb_integ_acc
    import hia_pkg::*;
#(
    parameter int ACC_W       = 11,
    parameter int OUT_W       = 3,
    parameter int IN_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic [IN_W-1:0]        din,
    input  logic                   carry_up,
    input  logic                   carry_dn,
    output logic [OUT_W-1:0]       dig_out,
    output logic [ACC_W-OUT_W-1:0] dac_code,
    output logic                   ovf
);
    localparam int DAC_W = ACC_W - OUT_W;

    logic [REQ_N-1:0] req_raw;
    logic [REQ_N-1:0] req_pulse;
    logic             up_pulse;
    logic             dn_pulse;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nxt;
    logic             wrap;

    assign req_raw[REQ_UP] = carry_up;
    assign req_raw[REQ_DN] = carry_dn;

    for (genvar g = 0; g < REQ_N; g++) begin : g_req
        hia_req_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_async (req_raw[g]),
            .pulse     (req_pulse[g])
        );
    end

    assign up_pulse = req_pulse[REQ_UP];
    assign dn_pulse = req_pulse[REQ_DN];

    hia_step_calc #(.ACC_W(ACC_W), .IN_W(IN_W)) u_calc (
        .acc     (acc_q),
        .tick    (tick),
        .din     (din),
        .inc     (up_pulse),
        .dec     (dn_pulse),
        .acc_nxt (acc_nxt),
        .wrap    (wrap)
    );

    hia_acc_reg #(.ACC_W(ACC_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_nxt (acc_nxt),
        .wrap    (wrap),
        .acc_q   (acc_q),
        .ovf_q   (ovf)
    );

    assign dig_out  = acc_q[ACC_W-1:DAC_W];
    assign dac_code = acc_q[DAC_W-1:0];
endmodule

// File: rtl/hia_checker.sv
module hia_checker #(
    parameter int ACC_W = 11,
    parameter int OUT_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tick,
    input logic                   up_pulse,
    input logic                   dn_pulse,
    input logic [OUT_W-1:0]       dig_out,
    input logic [ACC_W-OUT_W-1:0] dac_code,
    input logic                   ovf
);
    logic [ACC_W-1:0] vis;
    assign vis = {dig_out, dac_code};

    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (vis == '0 && !ovf));

    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !up_pulse && !dn_pulse) |=> $stable(vis));

    a_r4_up_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (up_pulse && !dn_pulse && !tick) |=> vis == ACC_W'($past(vis) + 1'b1));

    a_r5_dn_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_pulse && !up_pulse && !tick) |=> vis == ACC_W'($past(vis) - 1'b1));

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    a_r8_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (up_pulse && dn_pulse && !tick) |=> $stable(vis));

    a_r9_up_single: assert property (@(posedge clk) disable iff (!rst_n)
        up_pulse |=> !up_pulse);

    a_r9_dn_single: assert property (@(posedge clk) disable iff (!rst_n)
        dn_pulse |=> !dn_pulse);
endmodule

bind hyb_integ_acc hia_checker #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .up_pulse (up_pulse),
    .dn_pulse (dn_pulse),
    .dig_out  (dig_out),
    .dac_code (dac_code),
    .ovf      (ovf)
);

// File: tb/tb_hyb_integ_acc.sv
module tb_hyb_integ_acc;
    localparam int CLK_PERIOD = 10;
    localparam int ACC_W = 11;
    localparam int MAXV  = (1 << ACC_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] din = '0;
    logic       carry_up = 1'b0;
    logic       carry_dn = 1'b0;
    logic [2:0] dig_out;
    logic [7:0] dac_code;
    logic       ovf;

    int n_checks = 0;
    int n_fails  = 0;
    int acc_m    = 0;
    bit ovf_m    = 1'b0;
    bit done     = 1'b0;

    typedef struct {
        int    val;
        bit    ovf;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    hyb_integ_acc dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .din(din),
        .carry_up(carry_up), .carry_dn(carry_dn),
        .dig_out(dig_out), .dac_code(dac_code), .ovf(ovf)
    );

    // monitor: pops expectations and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (dig_out !== 3'(e.val >> 8) || dac_code !== 8'(e.val) || ovf !== e.ovf) begin
                    n_fails++;
                    $display("FAIL %s: actual dig=%0d dac=%0d ovf=%0b expected dig=%0d dac=%0d ovf=%0b",
                             e.tag, dig_out, dac_code, ovf, (e.val >> 8) & 7, e.val & 255, e.ovf);
                end
            end
        end
    end

    task automatic expect_now(input string tag);
        exp_t e;
        e.val = acc_m;
        e.ovf = ovf_m;
        e.tag = tag;
        exp_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    task automatic model_add(input int d);
        acc_m = acc_m + d;
        if (acc_m > MAXV || acc_m < 0) ovf_m = 1'b1;
        acc_m = acc_m & MAXV;
    endtask

    task automatic do_tick(input int d, input string tag);
        @(negedge clk);
        tick = 1'b1;
        din  = 3'(d);
        @(negedge clk);
        tick = 1'b0;
        model_add(d);
        expect_now(tag);
    endtask

    // raise a request, check after the fourth edge, then release it
    task automatic do_req(input bit up, input string tag);
        @(negedge clk);
        if (up) carry_up = 1'b1; else carry_dn = 1'b1;
        repeat (4) @(negedge clk);
        model_add(up ? 1 : -1);
        expect_now(tag);
        @(negedge clk);
        carry_up = 1'b0;
        carry_dn = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        acc_m = 0;
        ovf_m = 1'b0;
        repeat (2) @(negedge clk);
        expect_now("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R1 after reset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R1 reset state");

        // R2/R3: interval addition with several values
        do_tick(5, "R2 tick din=5");
        do_tick(0, "R2 tick din=0");
        do_tick(7, "R2 tick din=7");
        do_tick(3, "R3 tick din=3 fields");

        // R2: din changes with no tick have no effect
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            din = 3'(7 - i);
        end
        @(negedge clk);
        expect_now("R2 din ignored without tick");

        // R3: cross into the upper field (256 = dig 1, dac 0)
        while (acc_m < 300) do_tick(7, "R3 field split");
        expect_now("R3 dig_out/dac_code split");

        // R4 and R9: single increment while held
        @(negedge clk);
        carry_up = 1'b1;
        repeat (4) @(negedge clk);
        model_add(1);
        expect_now("R4 carry up +1");
        repeat (12) @(negedge clk);
        expect_now("R9 held up counts once");
        carry_up = 1'b0;
        repeat (5) @(negedge clk);

        // R9: re-arm after release
        do_req(1'b1, "R9 re-armed up");

        // R5: borrow
        do_req(1'b0, "R5 carry dn -1");

        // R8: both together cancel
        @(negedge clk);
        carry_up = 1'b1;
        carry_dn = 1'b1;
        repeat (4) @(negedge clk);
        expect_now("R8 up and dn cancel");
        carry_up = 1'b0;
        carry_dn = 1'b0;
        repeat (5) @(negedge clk);

        // R6: tick lands on the same edge as the up pulse
        @(negedge clk);
        carry_up = 1'b1;
        repeat (3) @(negedge clk);
        tick = 1'b1;
        din  = 3'd6;
        @(negedge clk);
        tick = 1'b0;
        model_add(7);
        expect_now("R6 tick plus carry merged");
        carry_up = 1'b0;
        repeat (5) @(negedge clk);

        // R6: tick with borrow
        @(negedge clk);
        carry_dn = 1'b1;
        repeat (3) @(negedge clk);
        tick = 1'b1;
        din  = 3'd2;
        @(negedge clk);
        tick = 1'b0;
        model_add(1);
        expect_now("R6 tick minus borrow merged");
        carry_dn = 1'b0;
        repeat (5) @(negedge clk);

        // R7: upward wrap and stickiness
        while (acc_m <= MAXV - 7) do_tick(7, "R7 approach top");
        do_tick(7, "R7 upward wrap sets ovf");
        do_tick(4, "R7 ovf sticky");

        // R7: downward wrap from zero
        do_reset();
        do_req(1'b0, "R7 borrow from zero wraps");
        do_tick(1, "R7 ovf sticky after underflow");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule